// File: doc/BRIEF.md
# Partitioned Packed YCbCr ALU

This block is a 32-bit integer ALU that runs in one of two modes. In baseline mode it is an ordinary full-width unit: add, subtract and round-half-up average with the carry rippling across all 32 bits, plus bitwise AND, OR and XOR. In packed mode the same word holds two 16-bit pixels, each split into one 6-bit luma field and two 5-bit chroma fields. Every arithmetic operation then works on all six fields at once, each field treated as an unsigned number.

Packed add and subtract saturate per field. A luma field clamps to 0..63 and a chroma field to 0..31. Packed average rounds half up and can never overflow its field. The six fields are produced by one 32-bit ripple adder. At every field boundary a mux either passes the carry on (baseline mode) or restarts the next segment with the operation's own carry-in (packed mode). Saturation and average are then derived from each segment's carry-out.

An optional output register gives one cycle of latency and a synchronous clear.

Top module: `pix_alu`

## Requirements
- R1: The packed-mode fields sit, from bit 0 upward, as luma-A [5:0], blue-chroma-A [10:6], red-chroma-A [15:11], luma-B [21:16], blue-chroma-B [26:22] and red-chroma-B [31:27]. No carry or borrow crosses a field edge in packed mode (`packed_en` = 1).
- R2: Packed add (op code 0) produces each field's unsigned sum, clamped to the field maximum (63 for a 6-bit field, 31 for a 5-bit field).
- R3: Packed subtract (op code 1) produces each field's unsigned difference, clamped to 0 when the second operand's field is larger.
- R4: Packed average (op code 2) produces (a + b + 1) >> 1 per field, computed with one extra bit so the largest inputs give the field maximum.
- R5: Baseline add (op 0) gives the 32-bit sum, with `carry_out` as bit 32. Baseline subtract (op 1) gives the 32-bit difference, with `carry_out` = 1 exactly when opa >= opb (no borrow).
- R6: Baseline average (op 2) gives bits [32:1] of the 33-bit value opa + opb + 1.
- R7: AND (op 3), OR (op 4) and XOR (op 5) are bitwise and give the same result in both modes.
- R8: `carry_out` is 0 in packed mode and for every op other than baseline add and subtract.
- R9: The reserved op codes 6 and 7 give a result of 0 and a `carry_out` of 0.
- R10: With OUT_REG = 1, the outputs show the result for the inputs presented one rising edge earlier. While `rst` is high at a rising edge, both outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high clear of the output register |
| packed_en | input | 1 | 1 = six-field packed mode, 0 = baseline 32-bit mode |
| op | input | 3 | Operation code: 0 add, 1 sub, 2 avg, 3 and, 4 or, 5 xor, 6-7 reserved |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Baseline add/sub carry (no-borrow for sub) |

## Verification
The bench builds the block with its default OUT_REG = 1, so every result travels through the output register. This brings the one-edge latency and the clear under reset within reach of the scoreboard. Directed vectors put each field exactly at its clamp edge: 63 + 1, 62 + 1, 31 + 1, 0 - 1 and the all-ones average. They also send a low-field overflow that would leak into its neighbour if a carry mux failed. A long run of random operands over all eight op codes in both modes then compares every field against a per-field reference model in the bench.

// File: rtl/pix_alu_pkg.sv
package pix_alu_pkg;

  localparam int DATA_W = 32;
  localparam int NLANE  = 6;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AVG = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5
  } alu_op_e;

  // lowest bit of each field; index NLANE returns the word width
  function automatic int lane_lo(input int idx);
    case (idx)
      0:       return 0;
      1:       return 6;
      2:       return 11;
      3:       return 16;
      4:       return 22;
      5:       return 27;
      default: return DATA_W;
    endcase
  endfunction

  function automatic int lane_w(input int idx);
    return lane_lo(idx + 1) - lane_lo(idx);
  endfunction

  function automatic logic [DATA_W-1:0] lane_start_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NLANE; i++) m[lane_lo(i)] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] lane_end_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NLANE; i++) m[lane_lo(i + 1) - 1] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pix_seg_adder.sv
module pix_seg_adder
  import pix_alu_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int NSEG = NLANE
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            inv_b,
  input  logic            cin,
  input  logic            cut,
  output logic [W-1:0]    sum,
  output logic [NSEG-1:0] seg_co,
  output logic            co
);
  localparam int SIW = $clog2(NSEG + 1);
  localparam logic [W-1:0] START_M = lane_start_mask();
  localparam logic [W-1:0] END_M   = lane_end_mask();

  logic [W-1:0] bb;
  assign bb = inv_b ? ~b : b;

  // single ripple chain; a mux at each segment start restarts the carry
  always_comb begin
    logic           c;
    logic [SIW-1:0] sidx;
    c      = cin;
    sidx   = '0;
    sum    = '0;
    seg_co = '0;
    for (int k = 0; k < W; k++) begin
      if (cut && START_M[k] && (k != 0)) c = cin;
      sum[k] = a[k] ^ bb[k] ^ c;
      c = (a[k] & bb[k]) | (a[k] & c) | (bb[k] & c);
      if (END_M[k]) begin
        seg_co[sidx] = c;
        sidx = sidx + 1'b1;
      end
    end
    co = c;
  end
endmodule

// File: rtl/pix_lane_fix.sv
module pix_lane_fix
  import pix_alu_pkg::*;
#(
  parameter int W = 6
) (
  input  logic [OP_W-1:0] op,
  input  logic            sat_en,
  input  logic [W-1:0]    s,
  input  logic            co,
  output logic [W-1:0]    r
);
  // turns a raw segment sum and its carry into the field result
  always_comb begin
    case (op)
      OP_ADD:  r = (sat_en && co)  ? '1 : s;
      OP_SUB:  r = (sat_en && !co) ? '0 : s;
      OP_AVG:  r = {co, s[W-1:1]};
      default: r = s;
    endcase
  end
endmodule

// File: rtl/pix_alu.sv
module pix_alu
  import pix_alu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              packed_en,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  logic              is_arith;
  logic              add_inv, add_cin;
  logic [DATA_W-1:0] raw_sum;
  logic [NLANE-1:0]  seg_co;
  logic              full_co;
  logic [DATA_W-1:0] base_r, pk_r, res_c;
  logic              co_c;

  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AVG);
  assign add_inv  = (op == OP_SUB);
  assign add_cin  = (op == OP_SUB) || (op == OP_AVG);

  pix_seg_adder #(.W(DATA_W), .NSEG(NLANE)) u_add (
    .a(opa), .b(opb), .inv_b(add_inv), .cin(add_cin), .cut(packed_en),
    .sum(raw_sum), .seg_co(seg_co), .co(full_co)
  );

  pix_lane_fix #(.W(DATA_W)) u_base (
    .op(op), .sat_en(1'b0), .s(raw_sum), .co(full_co), .r(base_r)
  );

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int LO = lane_lo(i);
    localparam int LW = lane_w(i);
    logic [LW-1:0] lr, la, lb;

    pix_lane_fix #(.W(LW)) u_fix (
      .op(op), .sat_en(1'b1), .s(raw_sum[LO +: LW]), .co(seg_co[i]), .r(lr)
    );
    assign pk_r[LO +: LW] = lr;
    assign la = opa[LO +: LW];
    assign lb = opb[LO +: LW];

    // R2: a clamped unsigned sum is never below either addend
    assert_sat_add_R2: assert property (@(posedge clk) disable iff (rst)
      (packed_en && op == OP_ADD) |-> (lr >= la && lr >= lb));
    // R3: a clamped unsigned difference never exceeds the minuend
    assert_sat_sub_R3: assert property (@(posedge clk) disable iff (rst)
      (packed_en && op == OP_SUB) |-> (lr <= la));
    // R4: an average lies between its two inputs
    assert_avg_range_R4: assert property (@(posedge clk) disable iff (rst)
      (packed_en && op == OP_AVG) |->
      ((lr >= la || lr >= lb) && (lr <= la || lr <= lb)));
  end

  always_comb begin
    res_c = '0;
    co_c  = 1'b0;
    if (is_arith) begin
      res_c = packed_en ? pk_r : base_r;
      co_c  = !packed_en && (op != OP_AVG) && full_co;
    end else begin
      case (op)
        OP_AND:  res_c = opa & opb;
        OP_OR:   res_c = opa | opb;
        OP_XOR:  res_c = opa ^ opb;
        default: res_c = '0;
      endcase
    end
  end

  // R5: the ripple chain matches a plain 33-bit sum in baseline mode
  assert_base_add_R5: assert property (@(posedge clk) disable iff (rst)
    (!packed_en && op == OP_ADD) |->
    ({co_c, res_c} == ({1'b0, opa} + {1'b0, opb})));
  // R7: xor result recovers the first operand
  assert_xor_R7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_XOR) |-> ((res_c ^ opb) == opa));

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        result    <= '0;
        carry_out <= 1'b0;
      end else begin
        result    <= res_c;
        carry_out <= co_c;
      end
    end
  end else begin : g_comb
    assign result    = res_c;
    assign carry_out = co_c;
  end
endmodule

// File: tb/pix_alu_bench.sv
`timescale 1ns/1ps
module pix_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        packed_en = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opa = '1;
  logic [31:0] opb = 32'd1;
  logic [31:0] result;
  logic        carry_out;

  int errors = 0;
  int checks = 0;

  logic [31:0] qr[$];
  logic        qc[$];
  string       qt[$];

  always #4 clk = ~clk;

  pix_alu #(.OUT_REG(1'b1)) u_pix_alu (
    .clk(clk), .rst(rst), .packed_en(packed_en), .op(op),
    .opa(opa), .opb(opb), .result(result), .carry_out(carry_out)
  );

  function automatic logic [31:0] pk6(input int y1, cb1, cr1, y2, cb2, cr2);
    return {5'(cr2), 5'(cb2), 6'(y2), 5'(cr1), 5'(cb1), 6'(y1)};
  endfunction

  function automatic void model(input logic pk, input logic [2:0] o,
                                input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] r, output logic c);
    int lo[7] = '{0, 6, 11, 16, 22, 27, 32};
    logic [32:0] t;
    int w, mx, x, y, v;
    r = '0;
    c = 1'b0;
    if (o == 3'd3) r = a & b;
    else if (o == 3'd4) r = a | b;
    else if (o == 3'd5) r = a ^ b;
    else if (o <= 3'd2) begin
      if (!pk) begin
        if (o == 3'd0) begin
          t = {1'b0, a} + {1'b0, b};
          r = t[31:0];
          c = t[32];
        end else if (o == 3'd1) begin
          r = a - b;
          c = (a >= b);
        end else begin
          t = {1'b0, a} + {1'b0, b} + 33'd1;
          r = t[32:1];
        end
      end else begin
        for (int i = 0; i < 6; i++) begin
          w  = lo[i+1] - lo[i];
          mx = (1 << w) - 1;
          x  = int'(a >> lo[i]) & mx;
          y  = int'(b >> lo[i]) & mx;
          if (o == 3'd0) begin
            v = x + y;
            if (v > mx) v = mx;
          end else if (o == 3'd1) begin
            v = x - y;
            if (v < 0) v = 0;
          end else begin
            v = (x + y + 1) / 2;
          end
          r = r | (32'(v) << lo[i]);
        end
      end
    end
  endfunction

  task automatic apply(input logic pk, input logic [2:0] o,
                       input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    logic [31:0] er;
    logic        ec;
    @(negedge clk);
    packed_en = pk;
    op        = o;
    opa       = a;
    opb       = b;
    model(pk, o, a, b, er, ec);
    qr.push_back(er);
    qc.push_back(ec);
    qt.push_back(tag);
  endtask

  // monitor: one registered result per rising edge, oldest first
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (qr.size() > 0) begin
        logic [31:0] er;
        logic        ec;
        string       tg;
        er = qr.pop_front();
        ec = qc.pop_front();
        tg = qt.pop_front();
        checks++;
        if (result !== er || carry_out !== ec) begin
          errors++;
          $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                   tg, result, carry_out, er, ec);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic string tag_of(input logic pk, input logic [2:0] o);
    if (o >= 3'd6) return "R9";
    if (o >= 3'd3) return "R7";
    if (pk) return (o == 3'd0) ? "R2" : (o == 3'd1) ? "R3" : "R4";
    return (o == 3'd2) ? "R6" : "R5";
  endfunction

  initial begin
    // R10: clear under reset, with live non-zero inputs
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== 32'h0 || carry_out !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: result=%h carry=%b expected result=0 carry=0",
               result, carry_out);
    end
    rst = 1'b0;

    // R10 latency, R5 baseline add and subtract
    apply(1'b0, 3'd0, 32'hFFFF_FFFF, 32'h1, "R10/R5 add wrap");
    apply(1'b0, 3'd0, 32'h1234_5678, 32'h1111_1111, "R5 add");
    apply(1'b0, 3'd1, 32'h5, 32'h7, "R5 sub borrow");
    apply(1'b0, 3'd1, 32'h7, 32'h7, "R5 sub equal");
    // R6 baseline average
    apply(1'b0, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 avg top");
    apply(1'b0, 3'd2, 32'h2, 32'h1, "R6 avg round");
    // R1 no carry across fields; baseline would give 0x40
    apply(1'b1, 3'd0, 32'h0000_003F, 32'h1, "R1 cut luma-A");
    apply(1'b1, 3'd0, pk6(1, 2, 3, 4, 5, 6), pk6(1, 2, 3, 4, 5, 6), "R1 field order");
    // R2 clamp edges
    apply(1'b1, 3'd0, pk6(63, 31, 31, 62, 30, 31), pk6(1, 1, 1, 1, 1, 0), "R2 clamp");
    apply(1'b1, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 all max");
    // R3 underflow
    apply(1'b1, 3'd1, pk6(0, 0, 5, 10, 31, 1), pk6(1, 31, 5, 3, 0, 2), "R3 clamp");
    // R4 average
    apply(1'b1, 3'd2, pk6(63, 31, 31, 1, 0, 4), pk6(62, 31, 30, 0, 0, 7), "R4 avg");
    // R7 logic both modes
    apply(1'b0, 3'd3, 32'hF0F0_A5A5, 32'hFF00_0FF0, "R7 and base");
    apply(1'b1, 3'd3, 32'hF0F0_A5A5, 32'hFF00_0FF0, "R7 and packed");
    apply(1'b1, 3'd4, 32'hF0F0_A5A5, 32'h0F00_0FF0, "R7 or packed");
    apply(1'b0, 3'd5, 32'hF0F0_A5A5, 32'h0F00_0FF0, "R7 xor base");
    // R8 carry suppressed
    apply(1'b1, 3'd0, 32'hFFFF_FFFF, 32'h1, "R8 packed carry");
    apply(1'b1, 3'd1, 32'h9, 32'h3, "R8 packed sub carry");
    apply(1'b0, 3'd2, 32'hFFFF_FFFF, 32'h1, "R8 avg carry");
    // R9 reserved codes
    apply(1'b0, 3'd6, 32'hDEAD_BEEF, 32'h1234_5678, "R9 op6");
    apply(1'b1, 3'd7, 32'hDEAD_BEEF, 32'h1234_5678, "R9 op7");

    for (int n = 0; n < 400; n++) begin
      logic        pk;
      logic [2:0]  o;
      logic [31:0] a, b;
      pk = 1'($urandom);
      o  = 3'($urandom);
      a  = $urandom;
      b  = $urandom;
      if (n % 4 == 0) a = a | 32'hFBDE_F7BD;
      apply(pk, o, a, b, tag_of(pk, o));
    end

    repeat (4) @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule